// File: doc/BRIEF.md
# SCSI Initiator Host Register Block

This block is the byte-wide register face that a host processor sees on a SCSI initiator controller. It decodes sixteen register slots on a four-byte address stride. Reads and writes at the same slot can reach different storage. A read-side file holds the status, interrupt cause, sequence step and configuration values. A write-side file holds the values the host last wrote, such as bus ID, timeouts, sync settings and transfer counts. The block drives a level interrupt line toward the host.

Every byte written to the command slot is decoded into a DMA flag and a 7-bit operation. Some operations act directly on the registers: chip reset, FIFO flush, bus reset, the command-complete response and the message-accepted response. The operations that need the bus phase engine are transfer, set ATN, both select variants and enable selection. For these the block sends a one-cycle request carrying the operation to that engine. When the engine acknowledges, the block loads the phase, cause and step values it reports and raises the interrupt. The host reads the interrupt-cause slot to take the interrupt. That read clears the interrupt and error status bits and drops the line.

Top module: `scsi_host_regs`

## Requirements
- R1: The slot index is address bits [5:2]. Address bits [1:0] and any bits above bit 5 are ignored.
- R2: After reset every read slot returns 0x00, except slot 0xE, which returns the identification code 0x04. The interrupt output and engine request are low.
- R3: Writes to slots 4, 5, 6, 7, 9 and 0xA go only to the write-side file. The values read at those slots do not change.
- R4: A write to slot 8 (config 1) or to slots 0xC to 0xF reads back unchanged. A write to slot 0xB (config 2) reads back ANDed with 0x15.
- R5: A read of slot 5 (interrupt cause) clears status bits 7 (interrupt), 6 (gross error) and 5 (parity error) and drops the interrupt output from the next cycle. Other status bits are kept.
- R6: Command op 0x03 (bus reset) sets the cause in slot 5 to 0x80. It raises the interrupt only when bit 6 of the written config 1 value is 0.
- R7: Command op 0x02 (chip reset) returns both register files to their reset values: everything 0x00, slot 0xE at 0x04, interrupt low.
- R8: Command op 0x01 (flush) sets the cause to 0x08 (function complete) and the sequence step in slot 6 to 0.
- R9: A recognised command with bit 7 set copies the written count bytes of slots 0 and 1 into the read side of slots 0 and 1. Without bit 7 there is no copy. A write to slot 0 or 1 clears status bit 4 (terminal count).
- R10: Command op 0x11 (command-complete response) sets status to 0x93 (interrupt, terminal count, status phase 3), the cause to 0x18, the step to 4, and raises the interrupt.
- R11: Command op 0x12 (message accepted) sets status to 0x93, the cause to 0x20 (disconnect), the step to 0, and raises the interrupt.
- R12: Ops 0x10, 0x1A, 0x42, 0x43 and 0x44 give a one-cycle engine request in the cycle after the write, carrying the op and the DMA flag. An engine acknowledge sets status to 0x90 OR'd with the reported phase, loads the reported cause and step, and raises the interrupt.
- R13: A command byte whose op is not listed above changes only the command slot 3. It issues no engine request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| host_addr | input | ADDR_W | Host byte address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read-side value of the addressed slot |
| irq | output | 1 | Level interrupt to the host |
| eng_req | output | 1 | One-cycle request to the phase engine |
| eng_op | output | 7 | Operation carried by the request |
| eng_dma | output | 1 | DMA flag carried by the request |
| eng_ack | input | 1 | Phase engine completion strobe |
| eng_phase | input | 3 | Bus phase reported with the acknowledge |
| eng_cause | input | 8 | Interrupt cause reported with the acknowledge |
| eng_step | input | 3 | Sequence step reported with the acknowledge |

## Verification
The configuration store is exercised with random data written through random address aliases. This separates correct index extraction and the config 2 mask from a design that uses the wrong address bits or masks the wrong slot. The command decoder is driven with every locally handled op, several delegated ops with and without the DMA flag, and an unlisted op. Each response is told apart by its exact status, cause and step bytes and by whether the engine request fires. Bus reset is issued once with the suppress bit set and once with it clear. The DMA copy is checked once before and once after a chip reset, which shows that the write-side file is really cleared.

// File: rtl/scsi_reg_pkg.sv
package scsi_reg_pkg;

   localparam int REG_IDX_W = 4;
   localparam int NREG      = 1 << REG_IDX_W;

   typedef logic [7:0]           byte_t;
   typedef logic [REG_IDX_W-1:0] idx_t;

   // Slot positions: fixed, host software decodes them
   localparam idx_t IDX_CNT_LO  = 4'h0;
   localparam idx_t IDX_CNT_MID = 4'h1;
   localparam idx_t IDX_CMD     = 4'h3;
   localparam idx_t IDX_STAT    = 4'h4;
   localparam idx_t IDX_CAUSE   = 4'h5;
   localparam idx_t IDX_STEP    = 4'h6;
   localparam idx_t IDX_CFG1    = 4'h8;
   localparam idx_t IDX_CFG2    = 4'hB;
   localparam idx_t IDX_ID      = 4'hE;

   // Operation codes
   localparam logic [6:0] OP_NOP     = 7'h00;
   localparam logic [6:0] OP_FLUSH   = 7'h01;
   localparam logic [6:0] OP_CHIPRST = 7'h02;
   localparam logic [6:0] OP_BUSRST  = 7'h03;
   localparam logic [6:0] OP_XFER    = 7'h10;
   localparam logic [6:0] OP_CCRESP  = 7'h11;
   localparam logic [6:0] OP_MSGOK   = 7'h12;
   localparam logic [6:0] OP_ATN     = 7'h1A;
   localparam logic [6:0] OP_SELATN  = 7'h42;
   localparam logic [6:0] OP_SELSTOP = 7'h43;
   localparam logic [6:0] OP_SELEN   = 7'h44;

   // Status bits
   localparam byte_t ST_IRQ   = 8'h80;
   localparam byte_t ST_GERR  = 8'h40;
   localparam byte_t ST_PERR  = 8'h20;
   localparam int    ST_TC_BIT = 4;
   localparam byte_t ST_TC    = 8'h10;
   localparam byte_t ST_PH_STATUS = 8'h03;
   localparam byte_t ST_RDCLR = ST_IRQ | ST_GERR | ST_PERR;

   // Cause bits
   localparam byte_t CA_BUSRST = 8'h80;
   localparam byte_t CA_DISC   = 8'h20;
   localparam byte_t CA_SVC    = 8'h10;
   localparam byte_t CA_DONE   = 8'h08;

   localparam byte_t STEP_CMD  = 8'h04;

   typedef struct packed {
      logic       dma;
      logic [6:0] op;
      logic       flush;
      logic       chip_rst;
      logic       bus_rst;
      logic       cc_resp;
      logic       msg_ok;
      logic       delegate;
      logic       known;
   } cmd_dec_t;

endpackage

// File: rtl/scsi_cmd_decode.sv
module scsi_cmd_decode
   import scsi_reg_pkg::*;
(
   input  byte_t    cmd_byte,
   output cmd_dec_t dec
);

   logic [6:0] op;
   logic       is_nop;

   assign op = cmd_byte[6:0];

   always_comb begin
      dec          = '0;
      dec.dma      = cmd_byte[7];
      dec.op       = op;
      is_nop       = (op == OP_NOP);
      dec.flush    = (op == OP_FLUSH);
      dec.chip_rst = (op == OP_CHIPRST);
      dec.bus_rst  = (op == OP_BUSRST);
      dec.cc_resp  = (op == OP_CCRESP);
      dec.msg_ok   = (op == OP_MSGOK);
      dec.delegate = (op == OP_XFER) || (op == OP_ATN) || (op == OP_SELATN)
                  || (op == OP_SELSTOP) || (op == OP_SELEN);
      dec.known    = is_nop | dec.flush | dec.chip_rst | dec.bus_rst
                  | dec.cc_resp | dec.msg_ok | dec.delegate;
   end

endmodule

// File: rtl/scsi_reg_bank.sv
module scsi_reg_bank
   import scsi_reg_pkg::*;
#(
   parameter byte_t ID_CODE         = 8'h04,
   parameter byte_t CFG2_KEEP       = 8'h15,
   parameter int    BUSRST_MASK_BIT = 6
)(
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  wr_en,
   input  logic                  rd_en,
   input  idx_t                  idx,
   input  byte_t                 wdata,
   input  cmd_dec_t              dec,
   input  logic                  eng_ack,
   input  logic [2:0]            eng_phase,
   input  byte_t                 eng_cause,
   input  logic [2:0]            eng_step,
   output logic [NREG-1:0][7:0]  rd_file,
   output logic                  irq,
   output logic                  eng_req,
   output logic [6:0]            eng_op,
   output logic                  eng_dma
);

   logic [NREG-1:0][7:0] rf, wf;
   logic [NREG-1:0][7:0] rf_init;
   logic                 cmd_wr;

   always_comb begin
      rf_init          = '0;
      rf_init[IDX_ID]  = ID_CODE;
   end

   assign cmd_wr  = wr_en && (idx == IDX_CMD);
   assign rd_file = rf;

   always_ff @(posedge clk) begin
      if (rst) begin
         rf      <= rf_init;
         wf      <= '0;
         irq     <= 1'b0;
         eng_req <= 1'b0;
         eng_op  <= '0;
         eng_dma <= 1'b0;
      end else begin
         eng_req <= 1'b0;
         // host takes the interrupt
         if (rd_en && idx == IDX_CAUSE) begin
            rf[IDX_STAT] <= rf[IDX_STAT] & ~ST_RDCLR;
            irq          <= 1'b0;
         end
         // phase engine completion
         if (eng_ack) begin
            rf[IDX_STAT]  <= ST_IRQ | ST_TC | {5'b0, eng_phase};
            rf[IDX_CAUSE] <= eng_cause;
            rf[IDX_STEP]  <= {5'b0, eng_step};
            irq           <= 1'b1;
         end
         if (wr_en) begin
            wf[idx] <= wdata;
            case (idx)
               IDX_CNT_LO, IDX_CNT_MID: rf[IDX_STAT][ST_TC_BIT] <= 1'b0;
               IDX_CFG1, 4'hC, 4'hD, 4'hE, 4'hF: rf[idx] <= wdata;
               IDX_CFG2: rf[idx] <= wdata & CFG2_KEEP;
               IDX_CMD: begin
                  rf[IDX_CMD] <= wdata;
                  if (dec.known && dec.dma) begin
                     rf[IDX_CNT_LO]  <= wf[IDX_CNT_LO];
                     rf[IDX_CNT_MID] <= wf[IDX_CNT_MID];
                  end
                  if (dec.flush) begin
                     rf[IDX_CAUSE] <= CA_DONE;
                     rf[IDX_STEP]  <= 8'h00;
                  end
                  if (dec.bus_rst) begin
                     rf[IDX_CAUSE] <= CA_BUSRST;
                     if (!wf[IDX_CFG1][BUSRST_MASK_BIT]) irq <= 1'b1;
                  end
                  if (dec.cc_resp) begin
                     rf[IDX_STAT]  <= ST_IRQ | ST_TC | ST_PH_STATUS;
                     rf[IDX_CAUSE] <= CA_SVC | CA_DONE;
                     rf[IDX_STEP]  <= STEP_CMD;
                     irq           <= 1'b1;
                  end
                  if (dec.msg_ok) begin
                     rf[IDX_STAT]  <= ST_IRQ | ST_TC | ST_PH_STATUS;
                     rf[IDX_CAUSE] <= CA_DISC;
                     rf[IDX_STEP]  <= 8'h00;
                     irq           <= 1'b1;
                  end
                  if (dec.delegate) begin
                     eng_req <= 1'b1;
                     eng_op  <= dec.op;
                     eng_dma <= dec.dma;
                  end
                  if (dec.chip_rst) begin
                     rf  <= rf_init;
                     wf  <= '0;
                     irq <= 1'b0;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   AST_IRQ_TAKEN: assert property (@(posedge clk) disable iff (rst)
      (rd_en && idx == IDX_CAUSE && !wr_en && !eng_ack) |=> !irq); // R5
   AST_BUSRST_CAUSE: assert property (@(posedge clk) disable iff (rst)
      (cmd_wr && wdata[6:0] == OP_BUSRST) |=> (rd_file[IDX_CAUSE] == CA_BUSRST)); // R6
   AST_CHIPRST_ID: assert property (@(posedge clk) disable iff (rst)
      (cmd_wr && wdata[6:0] == OP_CHIPRST) |=> (rd_file[IDX_ID] == ID_CODE && !irq)); // R7
   AST_FLUSH_DONE: assert property (@(posedge clk) disable iff (rst)
      (cmd_wr && wdata[6:0] == OP_FLUSH) |=> (rd_file[IDX_CAUSE] == CA_DONE && rd_file[IDX_STEP] == 8'h00)); // R8
   AST_REQ_FROM_CMD: assert property (@(posedge clk) disable iff (rst)
      eng_req |-> $past(cmd_wr)); // R12
   AST_UNKNOWN_QUIET: assert property (@(posedge clk) disable iff (rst)
      (cmd_wr && !dec.known) |=> !eng_req); // R13

endmodule

// File: rtl/scsi_host_regs.sv
module scsi_host_regs
   import scsi_reg_pkg::*;
#(
   parameter int    ADDR_W          = 8,
   parameter byte_t ID_CODE         = 8'h04,
   parameter byte_t CFG2_KEEP       = 8'h15,
   parameter int    BUSRST_MASK_BIT = 6,
   parameter bit    RDATA_REG       = 1'b0
)(
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [7:0]        host_wdata,
   output logic [7:0]        host_rdata,
   output logic              irq,
   output logic              eng_req,
   output logic [6:0]        eng_op,
   output logic              eng_dma,
   input  logic              eng_ack,
   input  logic [2:0]        eng_phase,
   input  logic [7:0]        eng_cause,
   input  logic [2:0]        eng_step
);

   localparam int IDX_LSB = 2;
   localparam int IDX_MSB = IDX_LSB + REG_IDX_W - 1;

   generate
      if (ADDR_W < IDX_MSB + 1) begin : g_bad_addr
         $error("ADDR_W too narrow for the slot index");
      end
      if (BUSRST_MASK_BIT < 0 || BUSRST_MASK_BIT > 7) begin : g_bad_bit
         $error("BUSRST_MASK_BIT outside the byte");
      end
   endgenerate

   idx_t                 idx;
   cmd_dec_t             dec;
   logic [NREG-1:0][7:0] rd_file;

   assign idx = host_addr[IDX_MSB:IDX_LSB];

   scsi_cmd_decode u_dec (
      .cmd_byte (host_wdata),
      .dec      (dec)
   );

   scsi_reg_bank #(
      .ID_CODE         (ID_CODE),
      .CFG2_KEEP       (CFG2_KEEP),
      .BUSRST_MASK_BIT (BUSRST_MASK_BIT)
   ) u_bank (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (host_wr),
      .rd_en     (host_rd),
      .idx       (idx),
      .wdata     (host_wdata),
      .dec       (dec),
      .eng_ack   (eng_ack),
      .eng_phase (eng_phase),
      .eng_cause (eng_cause),
      .eng_step  (eng_step),
      .rd_file   (rd_file),
      .irq       (irq),
      .eng_req   (eng_req),
      .eng_op    (eng_op),
      .eng_dma   (eng_dma)
   );

   generate
      if (RDATA_REG) begin : g_rd_flop
         always_ff @(posedge clk) begin
            if (rst)          host_rdata <= '0;
            else if (host_rd) host_rdata <= rd_file[idx];
         end
      end else begin : g_rd_comb
         assign host_rdata = rd_file[idx];
      end
   endgenerate

   AST_CFG2_STORE: assert property (@(posedge clk) disable iff (rst)
      (host_wr && idx == IDX_CFG2) |=> (rd_file[IDX_CFG2] == ($past(host_wdata) & CFG2_KEEP))); // R4
   AST_WRITE_ONLY_SLOT: assert property (@(posedge clk) disable iff (rst)
      (host_wr && idx == 4'h7) |=> $stable(rd_file[7])); // R3
   AST_ACK_IRQ: assert property (@(posedge clk) disable iff (rst)
      (eng_ack && !host_wr) |=> irq); // R12

endmodule

// File: tb/scsi_host_regs_test.sv
`timescale 1ns/100ps
module scsi_host_regs_test;

   logic       clk = 1'b0;
   logic       rst;
   logic [7:0] host_addr;
   logic       host_wr, host_rd;
   logic [7:0] host_wdata, host_rdata;
   logic       irq, eng_req, eng_dma, eng_ack;
   logic [6:0] eng_op;
   logic [2:0] eng_phase, eng_step;
   logic [7:0] eng_cause;

   int nchk = 0;
   int nerr = 0;
   logic [7:0] shadow [16];
   logic [7:0] snap   [16];

   always #2.5 clk = ~clk;

   scsi_host_regs uut (
      .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
      .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .irq(irq), .eng_req(eng_req), .eng_op(eng_op), .eng_dma(eng_dma),
      .eng_ack(eng_ack), .eng_phase(eng_phase), .eng_cause(eng_cause),
      .eng_step(eng_step)
   );

   function automatic logic [7:0] expect_store(input int slot, input logic [7:0] d);
      return (slot == 11) ? (d & 8'h15) : d;
   endfunction

   function automatic logic [7:0] alias_addr(input int slot);
      logic [1:0] lo = 2'($urandom);
      logic [1:0] hi = 2'($urandom);
      return {hi, slot[3:0], lo};
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input int slot, input logic [7:0] d);
      @(negedge clk);
      host_addr = alias_addr(slot); host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic rd(input int slot, output logic [7:0] v);
      @(negedge clk);
      host_addr = alias_addr(slot); host_rd = 1'b1;
      #1 v = host_rdata;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic rdchk(input string req, input int slot, input logic [7:0] exp);
      logic [7:0] v;
      rd(slot, v);
      chk(req, v, exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

   initial begin
      logic [7:0] v;
      void'($urandom(32'h1d5c));
      rst = 1'b1; host_addr = '0; host_wr = 0; host_rd = 0; host_wdata = '0;
      eng_ack = 0; eng_phase = '0; eng_cause = '0; eng_step = '0;
      repeat (4) @(negedge clk);
      rst = 1'b0;

      // R2 reset state
      for (int s = 0; s < 16; s++) rdchk("R2", s, (s == 14) ? 8'h04 : 8'h00);
      chk("R2 irq", {7'b0, irq}, 8'h00);
      chk("R2 req", {7'b0, eng_req}, 8'h00);

      // R1/R4 random config store through random aliases
      foreach (shadow[i]) shadow[i] = (i == 14) ? 8'h04 : 8'h00;
      for (int n = 0; n < 40; n++) begin
         int slots [6] = '{8, 11, 12, 13, 14, 15};
         int s = slots[$urandom_range(0, 5)];
         logic [7:0] d = 8'($urandom);
         wr(s, d);
         shadow[s] = expect_store(s, d);
         rdchk("R1 R4", s, shadow[s]);
      end
      for (int s = 8; s < 16; s++) if (s >= 11 || s == 8) rdchk("R4", s, shadow[s]);
      // R1 directed: upper and lower address bits ignored
      @(negedge clk); host_addr = 8'hF3; host_wdata = 8'h5A; host_wr = 1;
      @(negedge clk); host_wr = 0; host_addr = 8'h31; #1;
      chk("R1 alias", host_rdata, 8'h5A);

      // R3 write-only slots
      for (int s = 4; s < 8; s++) wr(s, 8'hFF);
      wr(9, 8'hEE); wr(10, 8'hDD);
      for (int s = 4; s < 8; s++) rdchk("R3", s, 8'h00);
      rdchk("R3", 9, 8'h00); rdchk("R3", 10, 8'h00);

      // R9 DMA copy of counts
      wr(0, 8'h34); wr(1, 8'h12);
      rdchk("R9 nocopy", 0, 8'h00);
      wr(3, 8'h00);
      rdchk("R9 nodma", 0, 8'h00);
      wr(3, 8'h80);
      rdchk("R9 lo", 0, 8'h34);
      rdchk("R9 mid", 1, 8'h12);

      // R10 command-complete response, then R5 read clear
      wr(3, 8'h11);
      chk("R10 irq", {7'b0, irq}, 8'h01);
      rdchk("R10 stat", 4, 8'h93);
      rdchk("R10 step", 6, 8'h04);
      rdchk("R10 cause", 5, 8'h18);
      chk("R5 irq", {7'b0, irq}, 8'h00);
      rdchk("R5 stat", 4, 8'h13);

      // R8 flush
      wr(3, 8'h01);
      rdchk("R8 cause", 5, 8'h08);
      rdchk("R8 step", 6, 8'h00);

      // R9 terminal count cleared by count write
      wr(0, 8'h77);
      rdchk("R9 tc", 4, 8'h03);

      // R11 message accepted
      wr(3, 8'h12);
      chk("R11 irq", {7'b0, irq}, 8'h01);
      rdchk("R11 stat", 4, 8'h93);
      rdchk("R11 step", 6, 8'h00);
      rdchk("R11 cause", 5, 8'h20);
      chk("R5 irq2", {7'b0, irq}, 8'h00);

      // R6 bus reset, suppressed then raised
      wr(8, 8'h40);
      wr(3, 8'h03);
      chk("R6 masked irq", {7'b0, irq}, 8'h00);
      rdchk("R6 cause", 5, 8'h80);
      wr(8, 8'h00);
      wr(3, 8'h03);
      chk("R6 irq", {7'b0, irq}, 8'h01);
      rdchk("R6 cause2", 5, 8'h80);
      chk("R5 irq3", {7'b0, irq}, 8'h00);

      // R12 delegated ops and engine acknowledge
      wr(3, 8'hC2);
      chk("R12 req", {7'b0, eng_req}, 8'h01);
      chk("R12 op", {1'b0, eng_op}, 8'h42);
      chk("R12 dma", {7'b0, eng_dma}, 8'h01);
      @(negedge clk);
      chk("R12 pulse", {7'b0, eng_req}, 8'h00);
      wr(3, 8'h10);
      chk("R12 req2", {7'b0, eng_req}, 8'h01);
      chk("R12 op2", {1'b0, eng_op}, 8'h10);
      chk("R12 dma2", {7'b0, eng_dma}, 8'h00);
      @(negedge clk);
      eng_ack = 1; eng_phase = 3'd1; eng_cause = 8'h18; eng_step = 3'd4;
      @(negedge clk);
      eng_ack = 0;
      chk("R12 irq", {7'b0, irq}, 8'h01);
      rdchk("R12 stat", 4, 8'h91);
      rdchk("R12 step", 6, 8'h04);
      rdchk("R12 cause", 5, 8'h18);

      // R13 unknown op changes only slot 3
      for (int s = 0; s < 16; s++) rd(s, snap[s]);
      wr(3, 8'hA5);
      chk("R13 req", {7'b0, eng_req}, 8'h00);
      chk("R13 irq", {7'b0, irq}, 8'h00);
      for (int s = 0; s < 16; s++) rdchk("R13", s, (s == 3) ? 8'hA5 : snap[s]);

      // R7 chip reset clears both files
      wr(8, 8'h40);
      wr(3, 8'h11);
      wr(3, 8'h02);
      chk("R7 irq", {7'b0, irq}, 8'h00);
      for (int s = 0; s < 16; s++) rdchk("R7", s, (s == 14) ? 8'h04 : 8'h00);
      wr(3, 8'h80);
      rdchk("R7 wfile", 0, 8'h00);
      wr(3, 8'h03);
      chk("R7 cfg1 cleared", {7'b0, irq}, 8'h01);

      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

endmodule